// File: doc/BRIEF.md
# Data-Stationary Pipeline Control Chain

This block carries the control word of each instruction through a five-stage in-order pipeline. The decoder builds one control word for the instruction in the decode slot, and the block registers that word at each stage boundary. Each stage reads its own group of fields at a fixed distance from decode. Execute fields are valid one cycle after decode, memory fields two cycles after, and write-back fields three cycles after. Fields that no later stage needs are dropped at each boundary.

The fetch/decode slot holds a valid bit and the raw instruction word, which it shows to an external decoder. The decoder's outputs come back into the block in the same cycle. A stall freezes the decode slot and puts an inert bubble into execute, while the stages below it keep moving. A flush empties the decode slot and takes priority over a stall. For each of execute, memory and write-back the block exposes the destination register number and a register-write flag, so that a hazard unit can compare pending writes against the source operands.

Top module: `ctl_chain`

## Requirements
- R1: A synchronous active-high reset leaves every stage empty: all valid flags, enables, fields and the held instruction are zero after the reset edge.
- R2: With no stall and no flush, the decode slot loads the fetch valid flag and instruction word at each clock edge.
- R3: An instruction that is valid in the decode slot with no stall shows its execute fields (extend mode, ALU source, ALU operation, destination select) on the execute outputs, with execute valid high, one cycle later.
- R4: The branch and memory-write fields of that instruction appear on the memory outputs two cycles after decode, with memory valid high.
- R5: Its memory-to-register select and register-write enable appear on the write-back outputs three cycles after decode.
- R6: Execute, memory and write-back each show the destination register and register-write flag of the instruction they hold. An empty stage shows zero for both.
- R7: During a stall without a flush, the decode slot keeps its valid flag and instruction word.
- R8: During a stall, execute receives a bubble. A bubble has its valid flag, register write, memory write, branch and every other field at zero, and it stays zero as it moves down to memory and write-back.
- R9: A stall does not hold the execute, memory or write-back boundaries: their contents move down one stage at the same edge.
- R10: A flush clears the decode slot to valid 0 and instruction 0. The instruction that was in decode still moves into execute if no stall is present.
- R11: When flush and stall are both high, the decode slot is cleared (flush wins) and execute still receives a bubble.
- R12: When the decode slot is empty, the decoder's control inputs are ignored and execute receives a bubble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stall_i | input | 1 | Freeze decode slot, bubble into execute |
| flush_i | input | 1 | Empty the decode slot |
| fetch_valid_i | input | 1 | Fetched instruction present |
| fetch_instr_i | input | INSTR_W | Fetched instruction word |
| dec_valid_o | output | 1 | Decode slot occupied |
| dec_instr_o | output | INSTR_W | Instruction word in the decode slot |
| dec_ext_mode_i | input | 1 | Decoder: immediate extend mode |
| dec_alu_src_i | input | 1 | Decoder: ALU second-operand select |
| dec_alu_op_i | input | ALUOP_W | Decoder: ALU operation |
| dec_dst_sel_i | input | 1 | Decoder: destination field select |
| dec_branch_i | input | 1 | Decoder: branch |
| dec_mem_wr_i | input | 1 | Decoder: memory write |
| dec_mem_to_reg_i | input | 1 | Decoder: load result select |
| dec_reg_wr_i | input | 1 | Decoder: register write |
| dec_dst_i | input | REG_AW | Decoder: destination register number |
| ex_valid_o | output | 1 | Execute stage occupied |
| ex_ext_mode_o | output | 1 | Execute: extend mode |
| ex_alu_src_o | output | 1 | Execute: ALU source select |
| ex_alu_op_o | output | ALUOP_W | Execute: ALU operation |
| ex_dst_sel_o | output | 1 | Execute: destination select |
| ex_dst_o | output | REG_AW | Execute: destination register |
| ex_wen_o | output | 1 | Execute: pending register write |
| mem_valid_o | output | 1 | Memory stage occupied |
| mem_branch_o | output | 1 | Memory: branch |
| mem_wr_o | output | 1 | Memory: memory write |
| mem_dst_o | output | REG_AW | Memory: destination register |
| mem_wen_o | output | 1 | Memory: pending register write |
| wb_valid_o | output | 1 | Write-back stage occupied |
| wb_mem_to_reg_o | output | 1 | Write-back: load result select |
| wb_dst_o | output | REG_AW | Write-back: destination register |
| wb_wen_o | output | 1 | Write-back: register write enable |

## Verification
The bench sweeps all eight combinations of stall, flush and fetch-valid, holding each one for several cycles. It also runs a long mixed pattern, so that stalls land next to flushes, empty decode slots and back-to-back instructions. A chain that froze every stage on a stall would repeat memory and write-back values. One that cleared the decode slot on a stall would lose the held instruction, and one that let a stall beat a flush would keep a squashed instruction alive. The bench drives nonzero decoder outputs while the decode slot is empty, so a chain that ignored the valid flag would send phantom writes down the pipe. A reset in the middle of the run checks that every stage returns to empty.

// File: rtl/pctl_pkg.sv
package pctl_pkg;

    // Action applied to a stage boundary register at the next edge.
    typedef enum logic [1:0] {
        ACT_LOAD  = 2'd0,
        ACT_HOLD  = 2'd1,
        ACT_CLEAR = 2'd2
    } stage_act_e;

    // Decode slot: flush outranks stall.
    function automatic stage_act_e front_act(input logic stall, input logic flush);
        if (flush)      return ACT_CLEAR;
        else if (stall) return ACT_HOLD;
        else            return ACT_LOAD;
    endfunction

    // Execute boundary: bubble on stall or on an empty decode slot.
    function automatic stage_act_e issue_act(input logic stall, input logic slot_valid);
        if (stall || !slot_valid) return ACT_CLEAR;
        else                      return ACT_LOAD;
    endfunction

endpackage

// File: rtl/pctl_front.sv
module pctl_front
    import pctl_pkg::*;
#(
    parameter int INSTR_W = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  stage_act_e         act_i,
    input  logic               valid_i,
    input  logic [INSTR_W-1:0] instr_i,
    output logic               valid_o,
    output logic [INSTR_W-1:0] instr_o
);

    typedef struct packed {
        logic               valid;
        logic [INSTR_W-1:0] instr;
    } slot_t;

    slot_t slot_d, slot_q;

    always_comb begin
        slot_d = slot_q;
        unique case (act_i)
            ACT_LOAD: begin
                slot_d.valid = valid_i;
                slot_d.instr = instr_i;
            end
            ACT_HOLD:  slot_d = slot_q;
            default:   slot_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) slot_q <= '0;
        else     slot_q <= slot_d;
    end

    assign valid_o = slot_q.valid;
    assign instr_o = slot_q.instr;

endmodule

// File: rtl/pctl_issue.sv
module pctl_issue
    import pctl_pkg::*;
#(
    parameter int REG_AW  = 5,
    parameter int ALUOP_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  stage_act_e         act_i,
    input  logic               ext_mode_i,
    input  logic               alu_src_i,
    input  logic [ALUOP_W-1:0] alu_op_i,
    input  logic               dst_sel_i,
    input  logic               branch_i,
    input  logic               mem_wr_i,
    input  logic               mem_to_reg_i,
    input  logic               reg_wr_i,
    input  logic [REG_AW-1:0]  dst_i,
    output logic               valid_o,
    output logic               ext_mode_o,
    output logic               alu_src_o,
    output logic [ALUOP_W-1:0] alu_op_o,
    output logic               dst_sel_o,
    output logic               branch_o,
    output logic               mem_wr_o,
    output logic               mem_to_reg_o,
    output logic               reg_wr_o,
    output logic [REG_AW-1:0]  dst_o
);

    typedef struct packed {
        logic               valid;
        logic               ext_mode;
        logic               alu_src;
        logic [ALUOP_W-1:0] alu_op;
        logic               dst_sel;
        logic               branch;
        logic               mem_wr;
        logic               mem_to_reg;
        logic               reg_wr;
        logic [REG_AW-1:0]  dst;
    } ex_word_t;

    ex_word_t ex_d, ex_q;

    always_comb begin
        ex_d = '0;
        if (act_i == ACT_LOAD) begin
            ex_d.valid      = 1'b1;
            ex_d.ext_mode   = ext_mode_i;
            ex_d.alu_src    = alu_src_i;
            ex_d.alu_op     = alu_op_i;
            ex_d.dst_sel    = dst_sel_i;
            ex_d.branch     = branch_i;
            ex_d.mem_wr     = mem_wr_i;
            ex_d.mem_to_reg = mem_to_reg_i;
            ex_d.reg_wr     = reg_wr_i;
            ex_d.dst        = dst_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ex_q <= '0;
        else     ex_q <= ex_d;
    end

    assign valid_o      = ex_q.valid;
    assign ext_mode_o   = ex_q.ext_mode;
    assign alu_src_o    = ex_q.alu_src;
    assign alu_op_o     = ex_q.alu_op;
    assign dst_sel_o    = ex_q.dst_sel;
    assign branch_o     = ex_q.branch;
    assign mem_wr_o     = ex_q.mem_wr;
    assign mem_to_reg_o = ex_q.mem_to_reg;
    assign reg_wr_o     = ex_q.reg_wr;
    assign dst_o        = ex_q.dst;

endmodule

// File: rtl/pctl_retire.sv
module pctl_retire #(
    parameter int REG_AW = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              valid_i,
    input  logic              branch_i,
    input  logic              mem_wr_i,
    input  logic              mem_to_reg_i,
    input  logic              reg_wr_i,
    input  logic [REG_AW-1:0] dst_i,
    output logic              mem_valid_o,
    output logic              mem_branch_o,
    output logic              mem_wr_o,
    output logic              mem_reg_wr_o,
    output logic [REG_AW-1:0] mem_dst_o,
    output logic              wb_valid_o,
    output logic              wb_mem_to_reg_o,
    output logic              wb_reg_wr_o,
    output logic [REG_AW-1:0] wb_dst_o
);

    typedef struct packed {
        logic              valid;
        logic              branch;
        logic              mem_wr;
        logic              mem_to_reg;
        logic              reg_wr;
        logic [REG_AW-1:0] dst;
    } mem_word_t;

    typedef struct packed {
        logic              valid;
        logic              mem_to_reg;
        logic              reg_wr;
        logic [REG_AW-1:0] dst;
    } wb_word_t;

    typedef struct packed {
        mem_word_t mem;
        wb_word_t  wb;
    } back_t;

    back_t back_d, back_q;

    always_comb begin
        back_d                = back_q;
        back_d.mem.valid      = valid_i;
        back_d.mem.branch     = branch_i;
        back_d.mem.mem_wr     = mem_wr_i;
        back_d.mem.mem_to_reg = mem_to_reg_i;
        back_d.mem.reg_wr     = reg_wr_i;
        back_d.mem.dst        = dst_i;
        // memory-stage fields are dropped here
        back_d.wb.valid       = back_q.mem.valid;
        back_d.wb.mem_to_reg  = back_q.mem.mem_to_reg;
        back_d.wb.reg_wr      = back_q.mem.reg_wr;
        back_d.wb.dst         = back_q.mem.dst;
    end

    always_ff @(posedge clk) begin
        if (rst) back_q <= '0;
        else     back_q <= back_d;
    end

    assign mem_valid_o     = back_q.mem.valid;
    assign mem_branch_o    = back_q.mem.branch;
    assign mem_wr_o        = back_q.mem.mem_wr;
    assign mem_reg_wr_o    = back_q.mem.reg_wr;
    assign mem_dst_o       = back_q.mem.dst;
    assign wb_valid_o      = back_q.wb.valid;
    assign wb_mem_to_reg_o = back_q.wb.mem_to_reg;
    assign wb_reg_wr_o     = back_q.wb.reg_wr;
    assign wb_dst_o        = back_q.wb.dst;

endmodule

// File: rtl/ctl_chain.sv
module ctl_chain
    import pctl_pkg::*;
#(
    parameter int INSTR_W = 32,
    parameter int REG_AW  = 5,
    parameter int ALUOP_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               stall_i,
    input  logic               flush_i,
    input  logic               fetch_valid_i,
    input  logic [INSTR_W-1:0] fetch_instr_i,
    output logic               dec_valid_o,
    output logic [INSTR_W-1:0] dec_instr_o,
    input  logic               dec_ext_mode_i,
    input  logic               dec_alu_src_i,
    input  logic [ALUOP_W-1:0] dec_alu_op_i,
    input  logic               dec_dst_sel_i,
    input  logic               dec_branch_i,
    input  logic               dec_mem_wr_i,
    input  logic               dec_mem_to_reg_i,
    input  logic               dec_reg_wr_i,
    input  logic [REG_AW-1:0]  dec_dst_i,
    output logic               ex_valid_o,
    output logic               ex_ext_mode_o,
    output logic               ex_alu_src_o,
    output logic [ALUOP_W-1:0] ex_alu_op_o,
    output logic               ex_dst_sel_o,
    output logic [REG_AW-1:0]  ex_dst_o,
    output logic               ex_wen_o,
    output logic               mem_valid_o,
    output logic               mem_branch_o,
    output logic               mem_wr_o,
    output logic [REG_AW-1:0]  mem_dst_o,
    output logic               mem_wen_o,
    output logic               wb_valid_o,
    output logic               wb_mem_to_reg_o,
    output logic [REG_AW-1:0]  wb_dst_o,
    output logic               wb_wen_o
);

    stage_act_e front_act_w;
    stage_act_e issue_act_w;

    logic ex_branch_w;
    logic ex_mem_wr_w;
    logic ex_mem_to_reg_w;

    always_comb begin
        front_act_w = front_act(stall_i, flush_i);
        issue_act_w = issue_act(stall_i, dec_valid_o);
    end

    pctl_front #(
        .INSTR_W (INSTR_W)
    ) front_i (
        .clk     (clk),
        .rst     (rst),
        .act_i   (front_act_w),
        .valid_i (fetch_valid_i),
        .instr_i (fetch_instr_i),
        .valid_o (dec_valid_o),
        .instr_o (dec_instr_o)
    );

    pctl_issue #(
        .REG_AW  (REG_AW),
        .ALUOP_W (ALUOP_W)
    ) issue_i (
        .clk          (clk),
        .rst          (rst),
        .act_i        (issue_act_w),
        .ext_mode_i   (dec_ext_mode_i),
        .alu_src_i    (dec_alu_src_i),
        .alu_op_i     (dec_alu_op_i),
        .dst_sel_i    (dec_dst_sel_i),
        .branch_i     (dec_branch_i),
        .mem_wr_i     (dec_mem_wr_i),
        .mem_to_reg_i (dec_mem_to_reg_i),
        .reg_wr_i     (dec_reg_wr_i),
        .dst_i        (dec_dst_i),
        .valid_o      (ex_valid_o),
        .ext_mode_o   (ex_ext_mode_o),
        .alu_src_o    (ex_alu_src_o),
        .alu_op_o     (ex_alu_op_o),
        .dst_sel_o    (ex_dst_sel_o),
        .branch_o     (ex_branch_w),
        .mem_wr_o     (ex_mem_wr_w),
        .mem_to_reg_o (ex_mem_to_reg_w),
        .reg_wr_o     (ex_wen_o),
        .dst_o        (ex_dst_o)
    );

    pctl_retire #(
        .REG_AW (REG_AW)
    ) retire_i (
        .clk             (clk),
        .rst             (rst),
        .valid_i         (ex_valid_o),
        .branch_i        (ex_branch_w),
        .mem_wr_i        (ex_mem_wr_w),
        .mem_to_reg_i    (ex_mem_to_reg_w),
        .reg_wr_i        (ex_wen_o),
        .dst_i           (ex_dst_o),
        .mem_valid_o     (mem_valid_o),
        .mem_branch_o    (mem_branch_o),
        .mem_wr_o        (mem_wr_o),
        .mem_reg_wr_o    (mem_wen_o),
        .mem_dst_o       (mem_dst_o),
        .wb_valid_o      (wb_valid_o),
        .wb_mem_to_reg_o (wb_mem_to_reg_o),
        .wb_reg_wr_o     (wb_wen_o),
        .wb_dst_o        (wb_dst_o)
    );

endmodule

// File: rtl/ctl_chain_chk.sv
module ctl_chain_chk #(
    parameter int INSTR_W = 32,
    parameter int REG_AW  = 5
) (
    input logic               clk,
    input logic               rst,
    input logic               stall_i,
    input logic               flush_i,
    input logic               dec_valid_o,
    input logic [INSTR_W-1:0] dec_instr_o,
    input logic               ex_valid_o,
    input logic               ex_wen_o,
    input logic [REG_AW-1:0]  ex_dst_o,
    input logic               mem_valid_o,
    input logic               mem_branch_o,
    input logic               mem_wr_o,
    input logic               mem_wen_o,
    input logic [REG_AW-1:0]  mem_dst_o,
    input logic               wb_valid_o,
    input logic               wb_wen_o,
    input logic [REG_AW-1:0]  wb_dst_o
);

    AST_STALL_HOLDS_SLOT: assert property (@(posedge clk) disable iff (rst)
        (stall_i && !flush_i) |=> ($stable(dec_valid_o) && $stable(dec_instr_o))); // R7

    AST_STALL_BUBBLE: assert property (@(posedge clk) disable iff (rst)
        stall_i |=> (!ex_valid_o && !ex_wen_o)); // R8

    AST_FLUSH_CLEARS_SLOT: assert property (@(posedge clk) disable iff (rst)
        flush_i |=> (!dec_valid_o && dec_instr_o == '0)); // R10

    AST_EMPTY_SLOT_BUBBLE: assert property (@(posedge clk) disable iff (rst)
        (!dec_valid_o && !stall_i) |=> !ex_valid_o); // R12

    AST_EX_TO_MEM: assert property (@(posedge clk) disable iff (rst)
        ex_valid_o |=> mem_valid_o); // R4

    AST_WEN_EX_TO_MEM: assert property (@(posedge clk) disable iff (rst)
        ex_wen_o |=> (mem_wen_o && mem_dst_o == $past(ex_dst_o))); // R6

    AST_WEN_MEM_TO_WB: assert property (@(posedge clk) disable iff (rst)
        mem_wen_o |=> (wb_wen_o && wb_dst_o == $past(mem_dst_o))); // R5

    AST_MEM_BUBBLE_INERT: assert property (@(posedge clk) disable iff (rst)
        !mem_valid_o |-> (!mem_wr_o && !mem_branch_o && !mem_wen_o)); // R8

    AST_WB_BUBBLE_INERT: assert property (@(posedge clk) disable iff (rst)
        !wb_valid_o |-> !wb_wen_o); // R8

endmodule

bind ctl_chain ctl_chain_chk #(
    .INSTR_W (INSTR_W),
    .REG_AW  (REG_AW)
) chk_i (
    .clk          (clk),
    .rst          (rst),
    .stall_i      (stall_i),
    .flush_i      (flush_i),
    .dec_valid_o  (dec_valid_o),
    .dec_instr_o  (dec_instr_o),
    .ex_valid_o   (ex_valid_o),
    .ex_wen_o     (ex_wen_o),
    .ex_dst_o     (ex_dst_o),
    .mem_valid_o  (mem_valid_o),
    .mem_branch_o (mem_branch_o),
    .mem_wr_o     (mem_wr_o),
    .mem_wen_o    (mem_wen_o),
    .mem_dst_o    (mem_dst_o),
    .wb_valid_o   (wb_valid_o),
    .wb_wen_o     (wb_wen_o),
    .wb_dst_o     (wb_dst_o)
);

// File: tb/ctl_chain_tb_top.sv
module ctl_chain_tb_top;

    localparam int CLK_P   = 10;
    localparam int INSTR_W = 32;
    localparam int REG_AW  = 5;
    localparam int ALUOP_W = 4;
    localparam int NCYC    = 600;

    logic               clk = 1'b0;
    logic               rst;
    logic               stall_i, flush_i, fetch_valid_i;
    logic [INSTR_W-1:0] fetch_instr_i;
    logic               dec_valid_o;
    logic [INSTR_W-1:0] dec_instr_o;
    logic               ex_valid_o, ex_ext_mode_o, ex_alu_src_o, ex_dst_sel_o, ex_wen_o;
    logic [ALUOP_W-1:0] ex_alu_op_o;
    logic [REG_AW-1:0]  ex_dst_o, mem_dst_o, wb_dst_o;
    logic               mem_valid_o, mem_branch_o, mem_wr_o, mem_wen_o;
    logic               wb_valid_o, wb_mem_to_reg_o, wb_wen_o;

    // Bench decoder: field positions inside the instruction word
    // ext[0] alu_src[1] alu_op[5:2] dst_sel[6] branch[7] mem_wr[8]
    // mem_to_reg[9] reg_wr[10] dst[15:11]
    // Driven even when the decode slot is empty (R12).
    logic dec_x_ext, dec_x_src, dec_x_dsel, dec_x_br, dec_x_mw, dec_x_m2r, dec_x_rw;
    logic [ALUOP_W-1:0] dec_x_op;
    logic [REG_AW-1:0]  dec_x_dst;
    assign dec_x_ext  = dec_instr_o[0];
    assign dec_x_src  = dec_instr_o[1];
    assign dec_x_op   = dec_instr_o[5:2];
    assign dec_x_dsel = dec_instr_o[6];
    assign dec_x_br   = dec_instr_o[7] | ~dec_valid_o;
    assign dec_x_mw   = dec_instr_o[8] | ~dec_valid_o;
    assign dec_x_m2r  = dec_instr_o[9];
    assign dec_x_rw   = dec_instr_o[10] | ~dec_valid_o;
    assign dec_x_dst  = dec_instr_o[15:11];

    always #(CLK_P/2) clk = ~clk;

    ctl_chain #(
        .INSTR_W (INSTR_W),
        .REG_AW  (REG_AW),
        .ALUOP_W (ALUOP_W)
    ) dut_i (
        .clk              (clk),
        .rst              (rst),
        .stall_i          (stall_i),
        .flush_i          (flush_i),
        .fetch_valid_i    (fetch_valid_i),
        .fetch_instr_i    (fetch_instr_i),
        .dec_valid_o      (dec_valid_o),
        .dec_instr_o      (dec_instr_o),
        .dec_ext_mode_i   (dec_x_ext),
        .dec_alu_src_i    (dec_x_src),
        .dec_alu_op_i     (dec_x_op),
        .dec_dst_sel_i    (dec_x_dsel),
        .dec_branch_i     (dec_x_br),
        .dec_mem_wr_i     (dec_x_mw),
        .dec_mem_to_reg_i (dec_x_m2r),
        .dec_reg_wr_i     (dec_x_rw),
        .dec_dst_i        (dec_x_dst),
        .ex_valid_o       (ex_valid_o),
        .ex_ext_mode_o    (ex_ext_mode_o),
        .ex_alu_src_o     (ex_alu_src_o),
        .ex_alu_op_o      (ex_alu_op_o),
        .ex_dst_sel_o     (ex_dst_sel_o),
        .ex_dst_o         (ex_dst_o),
        .ex_wen_o         (ex_wen_o),
        .mem_valid_o      (mem_valid_o),
        .mem_branch_o     (mem_branch_o),
        .mem_wr_o         (mem_wr_o),
        .mem_dst_o        (mem_dst_o),
        .mem_wen_o        (mem_wen_o),
        .wb_valid_o       (wb_valid_o),
        .wb_mem_to_reg_o  (wb_mem_to_reg_o),
        .wb_dst_o         (wb_dst_o),
        .wb_wen_o         (wb_wen_o)
    );

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    // Expected stage contents (tag = instruction word)
    logic               m_idv, m_exv, m_memv, m_wbv;
    logic [INSTR_W-1:0] m_id, m_ex, m_mem, m_wb;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [63:0] exp_ex(input logic v, input logic [INSTR_W-1:0] t);
        if (!v) return '0;
        return 64'({1'b1, t[0], t[1], t[5:2], t[6], t[15:11], t[10]});
    endfunction

    function automatic logic [63:0] exp_mem(input logic v, input logic [INSTR_W-1:0] t);
        if (!v) return '0;
        return 64'({1'b1, t[7], t[8], t[15:11], t[10]});
    endfunction

    function automatic logic [63:0] exp_wb(input logic v, input logic [INSTR_W-1:0] t);
        if (!v) return '0;
        return 64'({1'b1, t[9], t[15:11], t[10]});
    endfunction

    function automatic logic [63:0] exp_haz();
        logic [5:0] e, m, w;
        e = m_exv  ? {m_ex[15:11],  m_ex[10]}  : 6'd0;
        m = m_memv ? {m_mem[15:11], m_mem[10]} : 6'd0;
        w = m_wbv  ? {m_wb[15:11],  m_wb[10]}  : 6'd0;
        return 64'({e, m, w});
    endfunction

    task automatic check_all(input string id_req, input string ex_req, input string mem_req);
        chk(id_req,  64'({dec_valid_o, dec_instr_o}), 64'({m_idv, m_id}));
        chk(ex_req,  64'({ex_valid_o, ex_ext_mode_o, ex_alu_src_o, ex_alu_op_o,
                          ex_dst_sel_o, ex_dst_o, ex_wen_o}), exp_ex(m_exv, m_ex));
        chk(mem_req, 64'({mem_valid_o, mem_branch_o, mem_wr_o, mem_dst_o, mem_wen_o}),
                     exp_mem(m_memv, m_mem));
        chk("R5",    64'({wb_valid_o, wb_mem_to_reg_o, wb_dst_o, wb_wen_o}),
                     exp_wb(m_wbv, m_wb));
        chk("R6",    64'({ex_dst_o, ex_wen_o, mem_dst_o, mem_wen_o, wb_dst_o, wb_wen_o}),
                     exp_haz());
    endtask

    initial begin
        logic p_st, p_fl, p_idv, p_rst;
        rst = 1'b1; stall_i = 1'b0; flush_i = 1'b0;
        fetch_valid_i = 1'b0; fetch_instr_i = '0;
        m_idv = 0; m_exv = 0; m_memv = 0; m_wbv = 0;
        m_id = '0; m_ex = '0; m_mem = '0; m_wb = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1", 64'({dec_valid_o, dec_instr_o, ex_valid_o, ex_wen_o, mem_valid_o,
                       mem_wen_o, wb_valid_o, wb_wen_o}), 64'd0);
        rst = 1'b0;
        @(negedge clk);
        p_st = 0; p_fl = 0; p_idv = 0; p_rst = 0;
        for (int c = 0; c < NCYC; c++) begin
            logic st, fl, fv, r;
            logic [INSTR_W-1:0] ins;
            int h;
            string id_req, ex_req, mem_req;

            if (p_rst)                    id_req = "R1";
            else if (p_fl && p_st)        id_req = "R11";
            else if (p_fl)                id_req = "R10";
            else if (p_st)                id_req = "R7";
            else                          id_req = "R2";
            if (p_rst)                    ex_req = "R1";
            else if (p_st)                ex_req = "R8";
            else if (!p_idv)              ex_req = "R12";
            else                          ex_req = "R3";
            mem_req = p_st ? "R9" : "R4";
            check_all(id_req, ex_req, mem_req);

            h  = (c * 7) ^ (c >> 2);
            st = (h % 5 == 0);
            fl = (h % 9 == 2);
            fv = (c % 4 != 3);
            if (c >= 400 && c < 432) begin
                int combo = (c - 400) / 4;
                st = combo[0];
                fl = combo[1];
                fv = combo[2];
            end
            r   = (c == 300);
            ins = fv ? ((INSTR_W'(c) * 32'h9E3779B1) ^ 32'h00005A5A) : '0;

            p_st = st; p_fl = fl; p_idv = m_idv; p_rst = r;
            if (r) begin
                m_idv = 0; m_exv = 0; m_memv = 0; m_wbv = 0;
                m_id = '0; m_ex = '0; m_mem = '0; m_wb = '0;
            end else begin
                m_wbv  = m_memv; m_wb  = m_mem;
                m_memv = m_exv;  m_mem = m_ex;
                if (!st && m_idv) begin
                    m_exv = 1'b1; m_ex = m_id;
                end else begin
                    m_exv = 1'b0; m_ex = '0;
                end
                if (fl) begin
                    m_idv = 1'b0; m_id = '0;
                end else if (!st) begin
                    m_idv = fv; m_id = ins;
                end
            end

            rst = r; stall_i = st; flush_i = fl;
            fetch_valid_i = fv; fetch_instr_i = ins;
            @(negedge clk);
        end
        check_all(p_fl ? "R10" : "R2", p_st ? "R8" : "R3", p_st ? "R9" : "R4");
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule